// File: doc/BRIEF.md
# Banked GPIO controller with masked output writes

This block is a memory-mapped general-purpose I/O controller that serves four pin banks of 32, 22, 32 and 32 pins (118 pins in all) over a plain 32-bit register bus: a word address, a write enable, write data and combinational read data. For every pin it drives an output level and a drive enable, and it samples the pin's input level through a two-flop synchronizer.

Output levels are never read back over the bus. Instead, each bank exposes two write-only half-bank ports. One covers pins 0-15 and the other covers pins 16-31. In each word the upper sixteen bits act as an active-low per-bit write mask for the lower sixteen data bits. Software can therefore set or clear a single pin with one store and no read-modify-write. Per-bank direction and output-enable registers decide which pins actually drive. Two pins in bank 0 are wired as permanent outputs. Interrupt detection is not built; its register addresses read as zero.

Top module: `gpio_banked`

## Requirements
- R1: While reset is held and right after it, every output level and every drive enable is 0, every direction and output-enable register reads 0, and the bank 0 direction register reads 0x0000_0180.
- R2: A write to the lower half port of bank n (byte address 8·n) sets output bit i (0 ≤ i < 16) to write-data bit i for every i whose mask bit 16+i is 0.
- R3: A write to the upper half port of bank n (byte address 8·n + 4) sets bank pin 16+j to write-data bit j for every j whose mask bit 16+j is 0.
- R4: In a half port write, a mask bit of 1 leaves the matching output level unchanged, and writes to one half never alter the other half.
- R5: The direction register of bank n at byte address 0x204 + 0x40·n reads back what was written. A 1 marks the pin as an output and a 0 marks it as an input.
- R6: The output-enable register of bank n sits at byte address 0x208 + 0x40·n and reads back what was written. A pin's drive enable is 1 only when both its direction bit and its output-enable bit are 1.
- R7: Direction bits 7 and 8 of bank 0 always read 1, whatever value is written.
- R8: The pin data register of bank n at byte address 0x060 + 4·n returns the bank's input levels delayed by exactly two clock edges.
- R9: Register bits at or above a bank's pin count (bits 22-31 in bank 1) ignore writes and read as 0.
- R10: The half ports read as 0. Any address outside the mapped registers, the interrupt offsets included, reads as 0, and writes to it change no output level or drive enable.
- R11: Pins are numbered contiguously in bank order: pin k of bank n is top-level pin index base(n)+k, with bases 0, 32, 54 and 86. A write to one bank leaves the other banks' pins unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W (12) | Byte address of the register access, word aligned |
| busWe | input | 1 | Write strobe, captured on the rising clock edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for busAddr |
| pinIn | input | 118 | Sampled pin input levels, bank 0 in the low bits |
| pinOut | output | 118 | Pin output levels |
| pinOe | output | 118 | Pin drive enables, 1 = drive |

## Verification
The hardest case to reach from the ports is a half-port write whose mask is partly set. This matters most on the upper half of the 22-pin bank, where some data bits land on pins that do not exist. The stimulus table first loads known levels. It then issues writes with mixed mask patterns and an all-ones mask. After each write it compares the bank's slice of the flat output vector. The drive-enable combination is exercised by setting direction and output enable separately and in opposite orders, including the forced bank 0 bits. Synchronizer latency is checked by changing the inputs and reading the pin data register one edge and then two edges later.

// File: rtl/gpio_banked_pkg.sv
package gpio_banked_pkg;

  localparam int GPIO_BANKS = 4;
  localparam int REG_W      = 32;
  localparam int HALF_W     = REG_W / 2;
  localparam int BANK_IDX_W = $clog2(GPIO_BANKS);

  localparam int BANK_PINS [GPIO_BANKS] = '{32, 22, 32, 32};
  localparam logic [REG_W-1:0] FORCED_DIR [GPIO_BANKS] =
    '{32'h0000_0180, 32'h0, 32'h0, 32'h0};

  // byte address map
  localparam int HALF_PORT_BASE   = 'h000;
  localparam int HALF_PORT_STRIDE = 8;
  localparam int PIN_DATA_BASE    = 'h060;
  localparam int PIN_DATA_STRIDE  = 4;
  localparam int CFG_BASE         = 'h200;
  localparam int CFG_STRIDE       = 'h40;
  localparam int DIR_SUB          = 'h04;
  localparam int OE_SUB           = 'h08;

  function automatic int pinBase(int bank);
    int acc = 0;
    for (int i = 0; i < GPIO_BANKS; i++)
      if (i < bank) acc += BANK_PINS[i];
    return acc;
  endfunction

  localparam int TOTAL_PINS = pinBase(GPIO_BANKS);

  typedef enum logic [1:0] {RD_ZERO, RD_PIN, RD_DIR, RD_OE} rdKind_e;

  typedef struct packed {
    logic [GPIO_BANKS-1:0] wrLo;
    logic [GPIO_BANKS-1:0] wrHi;
    logic [GPIO_BANKS-1:0] wrDir;
    logic [GPIO_BANKS-1:0] wrOe;
    rdKind_e               rdKind;
    logic [BANK_IDX_W-1:0] rdBank;
  } gpioStrobe_t;

  // apply one half-port word: bits 31:16 active-low mask, 15:0 data
  function automatic logic [REG_W-1:0] mergeMasked(
    logic [REG_W-1:0] cur, logic [REG_W-1:0] word, logic lo, logic hi);
    logic [REG_W-1:0] en;
    logic [REG_W-1:0] val;
    en  = {hi ? ~word[REG_W-1:HALF_W] : '0, lo ? ~word[REG_W-1:HALF_W] : '0};
    val = {word[HALF_W-1:0], word[HALF_W-1:0]};
    return (cur & ~en) | (val & en);
  endfunction

endpackage

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
  import gpio_banked_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output gpioStrobe_t       strobes
);

  localparam int HALF_END = HALF_PORT_BASE + HALF_PORT_STRIDE * GPIO_BANKS;
  localparam int PIN_END  = PIN_DATA_BASE + PIN_DATA_STRIDE * GPIO_BANKS;
  localparam int CFG_END  = CFG_BASE + CFG_STRIDE * GPIO_BANKS;

  logic [31:0] addrW;
  logic [31:0] offset;
  logic [31:0] bankIdx;
  logic [GPIO_BANKS-1:0] bankOneHot;

  assign addrW = 32'(busAddr);

  always_comb begin
    strobes    = '0;
    offset     = '0;
    bankIdx    = '0;
    bankOneHot = '0;
    if (addrW[1:0] == 2'b00) begin
      if (addrW >= 32'(HALF_PORT_BASE) && addrW < 32'(HALF_END)) begin
        offset     = addrW - 32'(HALF_PORT_BASE);
        bankIdx    = offset / 32'(HALF_PORT_STRIDE);
        bankOneHot = GPIO_BANKS'(1) << bankIdx;
        if (busWe) begin
          if (offset[2]) strobes.wrHi = bankOneHot;
          else           strobes.wrLo = bankOneHot;
        end
      end else if (addrW >= 32'(PIN_DATA_BASE) && addrW < 32'(PIN_END)) begin
        offset         = addrW - 32'(PIN_DATA_BASE);
        bankIdx        = offset / 32'(PIN_DATA_STRIDE);
        strobes.rdKind = RD_PIN;
        strobes.rdBank = bankIdx[BANK_IDX_W-1:0];
      end else if (addrW >= 32'(CFG_BASE) && addrW < 32'(CFG_END)) begin
        offset     = addrW - 32'(CFG_BASE);
        bankIdx    = offset / 32'(CFG_STRIDE);
        bankOneHot = GPIO_BANKS'(1) << bankIdx;
        if (offset % 32'(CFG_STRIDE) == 32'(DIR_SUB)) begin
          strobes.rdKind = RD_DIR;
          strobes.rdBank = bankIdx[BANK_IDX_W-1:0];
          if (busWe) strobes.wrDir = bankOneHot;
        end else if (offset % 32'(CFG_STRIDE) == 32'(OE_SUB)) begin
          strobes.rdKind = RD_OE;
          strobes.rdBank = bankIdx[BANK_IDX_W-1:0];
          if (busWe) strobes.wrOe = bankOneHot;
        end
      end
    end
  end

endmodule

// File: rtl/gpio_banked_datapath.sv
module gpio_banked_datapath
  import gpio_banked_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  gpioStrobe_t           strobes,
  input  logic [REG_W-1:0]      busWdata,
  output logic [REG_W-1:0]      busRdata,
  input  logic [TOTAL_PINS-1:0] pinIn,
  output logic [TOTAL_PINS-1:0] pinOut,
  output logic [TOTAL_PINS-1:0] pinOe
);

  logic [REG_W-1:0] bankPin [GPIO_BANKS];
  logic [REG_W-1:0] bankDir [GPIO_BANKS];
  logic [REG_W-1:0] bankOe  [GPIO_BANKS];

  for (genvar b = 0; b < GPIO_BANKS; b++) begin : gBank
    localparam int W    = BANK_PINS[b];
    localparam int BASE = pinBase(b);
    localparam logic [W-1:0] FORCED = W'(FORCED_DIR[b]);

    logic [W-1:0] outQ;
    logic [W-1:0] dirQ;
    logic [W-1:0] oeQ;
    logic [W-1:0] syncQ [SYNC_STAGES];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outQ <= '0;
        dirQ <= FORCED;
        oeQ  <= '0;
      end else begin
        if (strobes.wrLo[b] || strobes.wrHi[b])
          outQ <= W'(mergeMasked(REG_W'(outQ), busWdata,
                                 strobes.wrLo[b], strobes.wrHi[b]));
        if (strobes.wrDir[b]) dirQ <= busWdata[W-1:0] | FORCED;
        if (strobes.wrOe[b])  oeQ  <= busWdata[W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      end else begin
        syncQ[0] <= pinIn[BASE +: W];
        for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      end
    end

    assign pinOut[BASE +: W] = outQ;
    assign pinOe[BASE +: W]  = dirQ & oeQ;
    assign bankPin[b] = REG_W'(syncQ[SYNC_STAGES-1]);
    assign bankDir[b] = REG_W'(dirQ);
    assign bankOe[b]  = REG_W'(oeQ);
  end

  always_comb begin
    unique case (strobes.rdKind)
      RD_PIN:  busRdata = bankPin[strobes.rdBank];
      RD_DIR:  busRdata = bankDir[strobes.rdBank];
      RD_OE:   busRdata = bankOe[strobes.rdBank];
      default: busRdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_banked.sv
module gpio_banked
  import gpio_banked_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWe,
  input  logic [REG_W-1:0]      busWdata,
  output logic [REG_W-1:0]      busRdata,
  input  logic [TOTAL_PINS-1:0] pinIn,
  output logic [TOTAL_PINS-1:0] pinOut,
  output logic [TOTAL_PINS-1:0] pinOe
);

  gpioStrobe_t strobes;

  gpio_banked_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strobes (strobes)
  );

  gpio_banked_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOe    (pinOe)
  );

endmodule

// File: rtl/gpio_banked_chk.sv
module gpio_banked_chk
  import gpio_banked_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [ADDR_W-1:0]     busAddr,
  input logic                  busWe,
  input logic [REG_W-1:0]      busWdata,
  input logic [REG_W-1:0]      busRdata,
  input logic [TOTAL_PINS-1:0] pinIn,
  input logic [TOTAL_PINS-1:0] pinOut,
  input logic [TOTAL_PINS-1:0] pinOe
);

  // R4: an all-ones mask on bank 0 lower port holds pins 0..15
  a_r4_mask_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(12'h000) && busWdata[31:16] == 16'hFFFF)
      |=> $stable(pinOut[15:0]));

  // R10: no write, no change on any pin output or drive enable
  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |=> ($stable(pinOut) && $stable(pinOe)));

  // R10: half ports read as zero
  a_r10_half_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr < ADDR_W'(12'h020)) |-> (busRdata == '0));

  // R7: bank 0 direction bits 7 and 8 always read as 1
  a_r7_forced_dir: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(12'h204)) |-> (busRdata[8:7] == 2'b11));

  // R9: bank 1 registers never show bits above its 22 pins
  a_r9_bank1_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(12'h064) || busAddr == ADDR_W'(12'h244) ||
     busAddr == ADDR_W'(12'h248)) |-> (busRdata[31:22] == '0));

  // R6: a drive enable only rises after a configuration write
  a_r6_oe_rise_needs_cfg: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|pinOe) |-> $past(busWe && busAddr >= ADDR_W'(12'h200)));

endmodule

bind gpio_banked gpio_banked_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/gpio_banked_tb.sv
module gpio_banked_tb;

  localparam int NPINS = 118;
  localparam int BASES [4] = '{0, 32, 54, 86};
  localparam int WIDS  [4] = '{32, 22, 32, 32};
  localparam int NVEC = 19;

  // kind: 0 = read data at addr, 1 = pinOut slice of bank, 2 = pinOe slice
  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [1:0]  kind;
    logic [1:0]  bank;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 12'h000, 32'h0000_A5A5, 2'd1, 2'd0, 32'h0000_A5A5, 4'd2},  // R2
    '{1'b1, 12'h004, 32'h0000_1234, 2'd1, 2'd0, 32'h1234_A5A5, 4'd3},  // R3
    '{1'b1, 12'h000, 32'hFF00_00FF, 2'd1, 2'd0, 32'h1234_A5FF, 4'd4},  // R4
    '{1'b1, 12'h004, 32'hFFFF_0000, 2'd1, 2'd0, 32'h1234_A5FF, 4'd4},  // R4
    '{1'b1, 12'h00C, 32'h0000_FFFF, 2'd1, 2'd1, 32'h003F_0000, 4'd9},  // R9
    '{1'b0, 12'h000, 32'h0,         2'd0, 2'd0, 32'h0,         4'd10}, // R10
    '{1'b1, 12'h018, 32'h0000_8001, 2'd1, 2'd3, 32'h0000_8001, 4'd11}, // R11
    '{1'b0, 12'h3FC, 32'h0,         2'd1, 2'd2, 32'h0,         4'd11}, // R11
    '{1'b1, 12'h204, 32'h0000_00F0, 2'd0, 2'd0, 32'h0000_01F0, 4'd7},  // R7
    '{1'b1, 12'h208, 32'hFFFF_FFFF, 2'd2, 2'd0, 32'h0000_01F0, 4'd6},  // R6
    '{1'b1, 12'h244, 32'hFFFF_FFFF, 2'd0, 2'd1, 32'h003F_FFFF, 4'd9},  // R9
    '{1'b1, 12'h248, 32'h0000_000F, 2'd2, 2'd1, 32'h0000_000F, 4'd6},  // R6
    '{1'b1, 12'h288, 32'h0000_00FF, 2'd2, 2'd2, 32'h0,         4'd6},  // R6
    '{1'b0, 12'h288, 32'h0,         2'd0, 2'd2, 32'h0000_00FF, 4'd6},  // R6
    '{1'b1, 12'h2C4, 32'hDEAD_BEEF, 2'd0, 2'd3, 32'hDEAD_BEEF, 4'd5},  // R5
    '{1'b1, 12'h218, 32'hFFFF_FFFF, 2'd0, 2'd0, 32'h0,         4'd10}, // R10
    '{1'b1, 12'h210, 32'hFFFF_FFFF, 2'd2, 2'd0, 32'h0000_01F0, 4'd10}, // R10
    '{1'b1, 12'h204, 32'h0000_0000, 2'd0, 2'd0, 32'h0000_0180, 4'd7},  // R7
    '{1'b0, 12'h204, 32'h0,         2'd2, 2'd0, 32'h0000_0180, 4'd7}   // R7
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [11:0]      busAddr = '0;
  logic             busWe = 1'b0;
  logic [31:0]      busWdata = '0;
  logic [31:0]      busRdata;
  logic [NPINS-1:0] pinIn = '0;
  logic [NPINS-1:0] pinOut;
  logic [NPINS-1:0] pinOe;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  gpio_banked u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  function automatic logic [31:0] slice(logic [NPINS-1:0] v, int b);
    logic [31:0] r = '0;
    for (int i = 0; i < WIDS[b]; i++) r[i] = v[BASES[b] + i];
    return r;
  endfunction

  task automatic check(int req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL R%0d %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired: actual hung expected finished");
      summary();
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);

    // R1: state while reset is held
    check(1, "pinOut in reset", slice(pinOut, 0) | slice(pinOut, 3), 32'h0);
    check(1, "pinOe in reset", slice(pinOe, 0) | slice(pinOe, 2), 32'h0);
    busRead(12'h204, rd); check(1, "bank0 dir in reset", rd, 32'h0000_0180);
    rstN = 1'b1;
    busRead(12'h244, rd); check(1, "bank1 dir after reset", rd, 32'h0);
    busRead(12'h2C8, rd); check(1, "bank3 oe after reset", rd, 32'h0);

    // table walk
    for (int k = 0; k < NVEC; k++) begin
      if (VECS[k].we) busWrite(VECS[k].addr, VECS[k].wdata);
      busRead(VECS[k].addr, rd);
      case (VECS[k].kind)
        2'd0: check(int'(VECS[k].req), $sformatf("vec %0d read", k), rd, VECS[k].exp);
        2'd1: check(int'(VECS[k].req), $sformatf("vec %0d pinOut", k),
                    slice(pinOut, int'(VECS[k].bank)), VECS[k].exp);
        default: check(int'(VECS[k].req), $sformatf("vec %0d pinOe", k),
                       slice(pinOe, int'(VECS[k].bank)), VECS[k].exp);
      endcase
    end

    // R11: bank 3 pins unchanged by bank 0 writes earlier in table
    check(11, "bank3 pinOut intact", slice(pinOut, 3), 32'h0000_8001);

    // R8: two-edge synchronizer latency
    @(negedge clk);
    busAddr = 12'h060;
    pinIn[0 +: 32]  = 32'hCAFE_F00D;
    pinIn[32 +: 22] = 22'h3F_FFFF;
    pinIn[54 +: 32] = 32'h1234_5678;
    pinIn[86 +: 32] = 32'h0F0F_0F0F;
    @(negedge clk); #1 check(8, "pin data after one edge", busRdata, 32'h0);
    @(negedge clk); #1 check(8, "pin data after two edges", busRdata, 32'hCAFE_F00D);
    busRead(12'h064, rd); check(9, "bank1 pin data width", rd, 32'h003F_FFFF);
    busRead(12'h068, rd); check(11, "bank2 pin data", rd, 32'h1234_5678);
    busRead(12'h06C, rd); check(8, "bank3 pin data", rd, 32'h0F0F_0F0F);

    // R1: reset asserted mid-run clears everything again
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check(1, "pinOut after mid reset", slice(pinOut, 0) | slice(pinOut, 1), 32'h0);
    check(1, "pinOe after mid reset", slice(pinOe, 0), 32'h0);
    busRead(12'h2C4, rd); check(1, "bank3 dir after mid reset", rd, 32'h0);
    busRead(12'h204, rd); check(1, "bank0 dir after mid reset", rd, 32'h0000_0180);
    busRead(12'h060, rd); check(1, "pin data in reset", rd, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    summary();
  end

endmodule